// File: doc/BRIEF.md
# Hub Status-Change Endpoint Responder

This block holds the change flags that a small USB hub reports on its interrupt status endpoint. There is one flag for the hub itself and one flag for each downstream port. A change-event strobe sets a flag. The flag then stays set until the host removes that one change with a clear-feature request. Reading the flags does not clear them, so the same change is reported on every poll until the host acknowledges it.

When a decoded IN token for the status endpoint arrives, the block makes its decision in that same cycle and issues a one-cycle response pulse on the next cycle. It requests a NAK handshake when nothing is pending or when the device is not yet configured. Otherwise it requests a one-byte data payload that carries the whole flag byte. Packet framing, CRC, PID generation, data toggling and request decoding stay in the surrounding serial engine and control logic.

Top module: `hub_chg_responder`

## Requirements
- R1: The payload byte puts the hub change flag at bit 0 and the flag for port k (1..NUM_PORTS) at bit k. Every bit above NUM_PORTS always reads 0 on data_o.
- R2: A token that finds all flags clear produces nak_o=1 with dv_o=0 in the next cycle.
- R3: A token that finds any flag set while configured produces dv_o=1 with nak_o=0 in the next cycle. data_o then carries the complete flag byte as it stood in the token cycle, not only the newest bits.
- R4: A flag stays set across any number of successful reads. It is removed only by a matching clear strobe, a bus reset or a deconfiguration.
- R5: While cfg_i=0, or while bus_reset_i is high in the token cycle, every token is answered with nak_o=1 and dv_o=0, whatever flags are pending.
- R6: A change event that arrives while cfg_i=0 is still latched. It is reported by the first token after cfg_i rises.
- R7: A clear strobe with clr_idx_i=0 clears only bit 0, and an index k in 1..NUM_PORTS clears only bit k. An index above NUM_PORTS changes no flag.
- R8: If a clear strobe and a change event hit the same bit in the same cycle, the bit stays set.
- R9: nak_o and dv_o are single-cycle pulses, never high together, and only appear in the cycle after a token. With the default HOLD_DATA=1, data_o keeps its last payload between pulses.
- R10: bus_reset_i clears every flag (it also overrides a same-cycle event) and drops the internal configured state. A falling cfg_i also clears every flag. After reset, nak_o, dv_o and data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset seen on the upstream port |
| cfg_i | input | 1 | Device configured level |
| evt_i | input | NUM_PORTS+1 (5) | Change-event strobes: bit 0 is the hub, bit k is port k |
| in_tok_i | input | 1 | Decoded IN token for the status endpoint |
| clr_i | input | 1 | Decoded clear-feature strobe |
| clr_idx_i | input | clog2(NUM_PORTS+1) (3) | Target of the clear: 0 is the hub, k is port k |
| nak_o | output | 1 | Request a NAK handshake |
| dv_o | output | 1 | Request a one-byte data payload |
| data_o | output | 8 | Payload byte |

## Verification
Some properties are checked on every clock cycle:
- the response rule for tokens (NAK when nothing is pending or when unconfigured, full byte otherwise, nothing without a token);
- the zero upper bits of the payload;
- persistence of set flags;
- the precedence of new events over clears;
- the effect of a bus reset.

Other behaviour only shows up over the bench's ordered scenarios:
- an event latched while unconfigured and reported after configuration;
- repeated reporting across several polls;
- per-index clears, including an out-of-range index that must do nothing;
- clearing of all flags on deconfiguration.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

   localparam int unsigned PAYLOAD_W = 8;

   typedef enum logic [1:0] {
      RSP_IDLE = 2'd0,
      RSP_NAK  = 2'd1,
      RSP_DATA = 2'd2
   } rsp_e;

endpackage

// File: rtl/hcr_flag_bit.sv
module hcr_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic q;

   // flush beats everything, a new event beats a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (flush_i) q <= 1'b0;
      else if (set_i)   q <= 1'b1;
      else if (clr_i)   q <= 1'b0;
   end

   assign q_o = q;

endmodule

// File: rtl/hcr_clr_decode.sv
module hcr_clr_decode #(
   parameter int unsigned NUM_CHG = 5,
   parameter int unsigned IDX_W   = 3
) (
   input  logic               clr_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [NUM_CHG-1:0] mask_o
);

   for (genvar g = 0; g < NUM_CHG; g++) begin : g_dec
      assign mask_o[g] = clr_i && (idx_i == IDX_W'(g));
   end

endmodule

// File: rtl/hcr_resp.sv
module hcr_resp
   import hcr_pkg::*;
#(
   parameter int unsigned FLAG_W    = 8,
   parameter bit          HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_i,
   input  logic              cfg_ok_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic              nak_o,
   output logic              dv_o,
   output logic [FLAG_W-1:0] data_o
);

   rsp_e rsp_d, rsp_q;
   logic any_set;

   assign any_set = |flags_i;

   always_comb begin
      rsp_d = RSP_IDLE;
      if (tok_i) begin
         if (cfg_ok_i && any_set) rsp_d = RSP_DATA;
         else                     rsp_d = RSP_NAK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_q <= RSP_IDLE;
      else        rsp_q <= rsp_d;
   end

   assign nak_o = (rsp_q == RSP_NAK);
   assign dv_o  = (rsp_q == RSP_DATA);

   if (HOLD_DATA) begin : g_hold
      logic [FLAG_W-1:0] pay_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 pay_q <= '0;
         else if (rsp_d == RSP_DATA) pay_q <= flags_i;
      end
      assign data_o = pay_q;
   end else begin : g_gate
      logic [FLAG_W-1:0] pay_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pay_q <= '0;
         else        pay_q <= (rsp_d == RSP_DATA) ? flags_i : '0;
      end
      assign data_o = pay_q;
   end

endmodule

// File: rtl/hub_chg_responder.sv
module hub_chg_responder
   import hcr_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned FLAG_W    = PAYLOAD_W,
   parameter bit          HOLD_DATA = 1'b1,
   localparam int unsigned NUM_CHG  = NUM_PORTS + 1,
   localparam int unsigned IDX_W    = (NUM_CHG > 1) ? $clog2(NUM_CHG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_reset_i,
   input  logic               cfg_i,
   input  logic [NUM_CHG-1:0] evt_i,
   input  logic               in_tok_i,
   input  logic               clr_i,
   input  logic [IDX_W-1:0]   clr_idx_i,
   output logic               nak_o,
   output logic               dv_o,
   output logic [FLAG_W-1:0]  data_o
);

   if (NUM_PORTS < 1 || NUM_CHG > FLAG_W) begin : g_bad_cfg
      $error("hub_chg_responder: NUM_PORTS must be 1..FLAG_W-1");
   end

   logic               cfg_q;
   logic               deconf;
   logic               flush;
   logic               cfg_ok;
   logic [NUM_CHG-1:0] clr_mask;
   logic [NUM_CHG-1:0] chg_q;
   logic [FLAG_W-1:0]  flag_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cfg_q <= 1'b0;
      else if (bus_reset_i) cfg_q <= 1'b0;
      else                  cfg_q <= cfg_i;
   end

   assign deconf = cfg_q & ~cfg_i;
   assign flush  = bus_reset_i | deconf;
   assign cfg_ok = cfg_i & ~bus_reset_i;

   hcr_clr_decode #(
      .NUM_CHG (NUM_CHG),
      .IDX_W   (IDX_W)
   ) u_dec (
      .clr_i  (clr_i),
      .idx_i  (clr_idx_i),
      .mask_o (clr_mask)
   );

   for (genvar g = 0; g < NUM_CHG; g++) begin : g_flag
      hcr_flag_bit u_bit (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush_i (flush),
         .set_i   (evt_i[g]),
         .clr_i   (clr_mask[g]),
         .q_o     (chg_q[g])
      );
   end

   assign flag_byte = FLAG_W'(chg_q);

   hcr_resp #(
      .FLAG_W    (FLAG_W),
      .HOLD_DATA (HOLD_DATA)
   ) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .tok_i    (in_tok_i),
      .cfg_ok_i (cfg_ok),
      .flags_i  (flag_byte),
      .nak_o    (nak_o),
      .dv_o     (dv_o),
      .data_o   (data_o)
   );

endmodule

// File: rtl/hcr_chk.sv
module hcr_chk #(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned FLAG_W    = 8,
   localparam int unsigned NUM_CHG  = NUM_PORTS + 1,
   localparam int unsigned IDX_W    = (NUM_CHG > 1) ? $clog2(NUM_CHG) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_reset_i,
   input logic               cfg_i,
   input logic [NUM_CHG-1:0] evt_i,
   input logic               in_tok_i,
   input logic               clr_i,
   input logic [IDX_W-1:0]   clr_idx_i,
   input logic               nak_o,
   input logic               dv_o,
   input logic [FLAG_W-1:0]  data_o,
   input logic [FLAG_W-1:0]  flags_q,
   input logic               cfg_q
);

   localparam logic [FLAG_W-1:0] LOW_MASK = FLAG_W'((1 << NUM_CHG) - 1);
   localparam logic [FLAG_W-1:0] UP_MASK  = ~LOW_MASK;

   logic [FLAG_W-1:0] evt_ext;
   logic              no_flush;

   assign evt_ext  = FLAG_W'(evt_i);
   assign no_flush = !bus_reset_i && !(cfg_q && !cfg_i);

   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dv_o |-> ((data_o & UP_MASK) == '0));

   a_r2_empty_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && flags_q == '0) |=> (nak_o && !dv_o));

   a_r3_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && cfg_i && !bus_reset_i && flags_q != '0)
      |=> (dv_o && !nak_o && data_o == $past(flags_q)));

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (no_flush && !clr_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   a_r5_unconf_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && (!cfg_i || bus_reset_i)) |=> (nak_o && !dv_o));

   // covers R6 (latched while unconfigured) and R8 (event beats clear)
   a_r8_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      no_flush |=> ((flags_q & $past(evt_ext)) == $past(evt_ext)));

   a_r7_bad_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (no_flush && clr_i && int'(clr_idx_i) > NUM_PORTS)
      |=> (flags_q == ($past(flags_q) | $past(evt_ext))));

   a_r9_no_tok_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_tok_i |=> (!nak_o && !dv_o));

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(nak_o && dv_o));

   a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (flags_q == '0 && !cfg_q));

endmodule

bind hub_chg_responder hcr_chk #(
   .NUM_PORTS (NUM_PORTS),
   .FLAG_W    (FLAG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_reset_i (bus_reset_i),
   .cfg_i       (cfg_i),
   .evt_i       (evt_i),
   .in_tok_i    (in_tok_i),
   .clr_i       (clr_i),
   .clr_idx_i   (clr_idx_i),
   .nak_o       (nak_o),
   .dv_o        (dv_o),
   .data_o      (data_o),
   .flags_q     (flag_byte),
   .cfg_q       (cfg_q)
);

// File: tb/hub_chg_responder_bench.sv
module hub_chg_responder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_reset_i = 1'b0;
   logic       cfg_i = 1'b0;
   logic [4:0] evt_i = '0;
   logic       in_tok_i = 1'b0;
   logic       clr_i = 1'b0;
   logic [2:0] clr_idx_i = '0;
   logic       nak_o;
   logic       dv_o;
   logic [7:0] data_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   hub_chg_responder u_hub_chg_responder (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_reset_i (bus_reset_i),
      .cfg_i       (cfg_i),
      .evt_i       (evt_i),
      .in_tok_i    (in_tok_i),
      .clr_i       (clr_i),
      .clr_idx_i   (clr_idx_i),
      .nak_o       (nak_o),
      .dv_o        (dv_o),
      .data_o      (data_o)
   );

   typedef struct packed {
      logic       cfg;
      logic       brst;
      logic [4:0] evt;
      logic       clr;
      logic [2:0] idx;
      logic       tok;
      logic       x_nak;
      logic       x_dv;
      logic [7:0] x_data;
   } vec_t;

   // response reflects the flags as they stood before the vector's own update
   localparam vec_t VEC [24] = '{
      '{1'b0,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b1,1'b0,8'h00}, // 0  R2/R5 empty, unconfigured
      '{1'b0,1'b0,5'b00100,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h00}, // 1  R6 port2 event unconfigured
      '{1'b0,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b1,1'b0,8'h00}, // 2  R5 pending but NAK
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h04}, // 3  R6 reported after cfg
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h04}, // 4  R4 still reported
      '{1'b1,1'b0,5'b00001,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h04}, // 5  R3 hub event, old byte
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h05}, // 6  R3 whole byte
      '{1'b1,1'b0,5'b00000,1'b1,3'd2,1'b1, 1'b0,1'b1,8'h05}, // 7  R7 clear port2
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h01}, // 8  R7 only bit2 gone
      '{1'b1,1'b0,5'b00000,1'b1,3'd6,1'b0, 1'b0,1'b0,8'h01}, // 9  R7 bad index
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h01}, // 10 R7 no effect
      '{1'b1,1'b0,5'b10000,1'b1,3'd0,1'b0, 1'b0,1'b0,8'h01}, // 11 R7 clear hub, port4 event
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h10}, // 12 R1 port4 at bit4
      '{1'b1,1'b0,5'b10000,1'b1,3'd4,1'b1, 1'b0,1'b1,8'h10}, // 13 R8 clear+event same bit
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h10}, // 14 R8 bit stays
      '{1'b1,1'b0,5'b00000,1'b1,3'd4,1'b0, 1'b0,1'b0,8'h10}, // 15 R4 clear port4
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b1,1'b0,8'h10}, // 16 R2 empty NAK
      '{1'b1,1'b0,5'b11110,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h10}, // 17 all ports change
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b0,1'b1,8'h1E}, // 18 R3/R1 full byte
      '{1'b1,1'b1,5'b00000,1'b0,3'd0,1'b1, 1'b1,1'b0,8'h1E}, // 19 R5/R10 reset same cycle
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b1,1'b0,8'h1E}, // 20 R10 flags gone
      '{1'b1,1'b0,5'b00010,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h1E}, // 21 port1 event
      '{1'b0,1'b0,5'b00000,1'b0,3'd0,1'b0, 1'b0,1'b0,8'h1E}, // 22 R10 deconfigure
      '{1'b1,1'b0,5'b00000,1'b0,3'd0,1'b1, 1'b1,1'b0,8'h1E}  // 23 R10 cleared by deconfig
   };

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, leave at the next falling edge
   task automatic apply(input logic cfg, input logic brst, input logic [4:0] evt,
                        input logic clr, input logic [2:0] idx, input logic tok);
      cfg_i = cfg; bus_reset_i = brst; evt_i = evt;
      clr_i = clr; clr_idx_i = idx; in_tok_i = tok;
      @(negedge clk);
      bus_reset_i = 1'b0; evt_i = '0; clr_i = 1'b0; in_tok_i = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "reset nak", {7'd0, nak_o}, 8'h00);
      check("R10", "reset dv", {7'd0, dv_o}, 8'h00);
      check("R10", "reset data", data_o, 8'h00);

      for (int i = 0; i < 24; i++) begin
         apply(VEC[i].cfg, VEC[i].brst, VEC[i].evt, VEC[i].clr, VEC[i].idx, VEC[i].tok);
         check("R9", $sformatf("v%0d nak", i), {7'd0, nak_o}, {7'd0, VEC[i].x_nak});
         check("R9", $sformatf("v%0d dv", i), {7'd0, dv_o}, {7'd0, VEC[i].x_dv});
         check("R3", $sformatf("v%0d data", i), data_o, VEC[i].x_data);
      end

      // R9: single pulse, payload held afterwards
      apply(1'b1, 1'b0, 5'b00011, 1'b0, 3'd0, 1'b0);
      apply(1'b1, 1'b0, 5'b00000, 1'b0, 3'd0, 1'b1);
      check("R3", "payload 03", data_o, 8'h03);
      apply(1'b1, 1'b0, 5'b00000, 1'b0, 3'd0, 1'b0);
      check("R9", "dv falls", {7'd0, dv_o}, 8'h00);
      check("R9", "nak quiet", {7'd0, nak_o}, 8'h00);
      check("R9", "data held", data_o, 8'h03);

      // R10: bus reset beats a same-cycle event
      apply(1'b1, 1'b1, 5'b00100, 1'b0, 3'd0, 1'b0);
      apply(1'b1, 1'b0, 5'b00000, 1'b0, 3'd0, 1'b1);
      check("R10", "reset beats event", {6'd0, nak_o, dv_o}, 8'h02);

      // R1: every change bit set, upper bits stay zero
      apply(1'b1, 1'b0, 5'b11111, 1'b0, 3'd0, 1'b0);
      apply(1'b1, 1'b0, 5'b00000, 1'b0, 3'd0, 1'b1);
      check("R1", "all flags", data_o, 8'h1F);
      check("R1", "upper bits", {5'd0, data_o[7:5]}, 8'h00);

      // R7: hub clear touches only bit 0
      apply(1'b1, 1'b0, 5'b00000, 1'b1, 3'd0, 1'b0);
      apply(1'b1, 1'b0, 5'b00000, 1'b0, 3'd0, 1'b1);
      check("R7", "hub clear", data_o, 8'h1E);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule